// File: doc/BRIEF.md
# Paged SPI Register Access Master

This block is an SPI master that performs one register access at a time on a peripheral whose register space is split into pages. Each request carries an 18-bit descriptor, a write flag, a masked-update flag, 16 bits of write data and a 16-bit mask. The block remembers which page it last selected on the peripheral. Before an access to a different page it sends a page-select frame. It then sends the access frame and finishes with a one-cycle `done` pulse. For a read, the data is valid on `rdata` when `done` pulses.

A masked update reads the register and merges the new bits under the mask. It writes the result back, and no other frame can enter between the read and the write. The SPI side runs in mode 0. SCLK idles low, MOSI changes while SCLK is low, and MISO is sampled on the rising edge. The SCLK half period is `HALF` system clocks.

The sequencer has four states. `S_IDLE` waits for a request. `S_PAGE` runs the page-select frame. `S_XFER` runs the read or write frame. `S_WBACK` runs the write-back of a masked update. The transitions are:
- `S_IDLE` goes to `S_PAGE` when a request targets a page other than the cached one.
- `S_IDLE` goes to `S_XFER` when the request targets the cached page.
- `S_PAGE` goes to `S_XFER` when the page-select frame finishes.
- `S_XFER` goes to `S_WBACK` when the frame finishes and the request is a masked update.
- `S_XFER` goes to `S_IDLE` when the frame finishes and the request is a plain read or write.
- `S_WBACK` goes to `S_IDLE` when the write-back frame finishes.

Top module: `pgspi_master`

## Requirements
- R1: After reset, cs_n is high, sclk is low, busy and done are low, and the cached page is 0, so a first access to page 0 sends no page-select frame.
- R2: Descriptor layout: bits 7:0 are the in-page address, bits 15:8 the page, and bits 17:16 the length. A length value of 2 means two data bytes; any other value means one data byte.
- R3: When the requested page differs from the cached page, a page-select frame is sent first. It is two bytes: 0x01 followed by the new page. The cache then holds the new page.
- R4: When the requested page equals the cached page, only the access frame is sent.
- R5: A read frame starts with the address byte with bit 7 set, followed by one or two 0x00 bytes. The bytes on MISO during those filler bytes are the result, most significant byte first. A one-byte result is zero-extended to 16 bits.
- R6: A write frame starts with the address byte with bit 7 clear. The data follows: both bytes most significant first for a length of 2, otherwise only wdata[7:0].
- R7: Every access frame carries exactly one more byte than the data length.
- R8: Mode 0 signalling. SCLK is low whenever cs_n is high. MOSI is stable while SCLK is high. Each SCLK high phase lasts HALF clock cycles.
- R9: Between consecutive frames, cs_n stays high for at least one SCLK period (2*HALF clocks).
- R10: A masked update sends a read frame and then a write frame of (old & ~mask) | (wdata & mask) to the same register, with no frame between them. rdata returns the old value.
- R11: A request is taken only while busy is low. busy is high from the cycle after acceptance until done. done is a single-cycle pulse and coincides with busy falling.
- R12: A request presented while busy is high is ignored: it produces no frame and no page change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_desc | input | 18 | Register descriptor: length, page, address |
| req_write | input | 1 | 1 = write, 0 = read (ignored when req_rmw is set) |
| req_rmw | input | 1 | Masked read-modify-write request |
| req_wdata | input | 16 | Write data or new bits for a masked update |
| req_mask | input | 16 | Bits to replace in a masked update |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read result, or the old value of a masked update; zero after a write |
| sclk | output | 1 | SPI clock, idle low |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | Serial data to the peripheral |
| miso | input | 1 | Serial data from the peripheral |

## Verification
Two events fall in the same cycle: the end of one frame and the launch of the next. This happens when a page-select frame is chained to its access frame, and when the read of a masked update is chained to its write-back. A page change and a masked update that itself changes page provoke it. A behavioural peripheral on the SPI pins decodes every frame, so each frame's bytes and byte count can be compared with the expected sequence. The chip-select high time between the chained frames is measured in clock cycles and must not fall below one SCLK period. A request held while busy must leave the frame count and the peripheral's page unchanged.

// File: rtl/pgspi_pkg.sv
package pgspi_pkg;
    localparam int BYTE_W    = 8;
    localparam int DATA_W    = 16;
    localparam int DESC_W    = 18;
    localparam int FRAME_W   = 24;
    localparam logic [BYTE_W-1:0] PAGE_SEL_ADDR = 8'h01;
    localparam logic [1:0] LEN_TWO = 2'd2;

    typedef enum logic [1:0] {
        S_IDLE,
        S_PAGE,
        S_XFER,
        S_WBACK
    } mst_state_e;

    typedef enum logic [2:0] {
        F_IDLE,
        F_LOW,
        F_HIGH,
        F_TAIL,
        F_GAP
    } frm_state_e;
endpackage

// File: rtl/pgspi_tick.sv
module pgspi_tick #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!en || cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = en && (cnt == LAST);
endmodule

// File: rtl/pgspi_frame.sv
module pgspi_frame
    import pgspi_pkg::*;
#(
    parameter int HALF = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [FRAME_W-1:0]   tx,
    input  logic                 three,
    output logic                 fin,
    output logic [DATA_W-1:0]    rx,
    output logic                 sclk,
    output logic                 cs_n,
    output logic                 mosi,
    input  logic                 miso
);
    localparam int BCW = $clog2(FRAME_W + 1);
    localparam logic [BCW-1:0] BITS_3 = BCW'(3 * BYTE_W);
    localparam logic [BCW-1:0] BITS_2 = BCW'(2 * BYTE_W);

    frm_state_e           st;
    logic [FRAME_W-1:0]   txsh;
    logic [DATA_W-1:0]    rxsh;
    logic [BCW-1:0]       bits;
    logic                 gapc;
    logic                 tick;
    logic                 tick_en;
    logic                 load;

    assign tick_en = (st != F_IDLE);

    pgspi_tick #(.HALF(HALF)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (tick_en),
        .tick (tick)
    );

    assign fin  = (st == F_GAP) && tick && gapc;
    assign load = start && ((st == F_IDLE) || fin);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= F_IDLE;
            txsh <= '0;
            rxsh <= '0;
            bits <= '0;
            gapc <= 1'b0;
            sclk <= 1'b0;
            cs_n <= 1'b1;
        end else if (load) begin
            st   <= F_LOW;
            txsh <= tx;
            bits <= three ? BITS_3 : BITS_2;
            gapc <= 1'b0;
            sclk <= 1'b0;
            cs_n <= 1'b0;
        end else begin
            unique case (st)
                F_IDLE: ;
                F_LOW: if (tick) begin
                    sclk <= 1'b1;
                    rxsh <= {rxsh[DATA_W-2:0], miso};
                    st   <= F_HIGH;
                end
                F_HIGH: if (tick) begin
                    sclk <= 1'b0;
                    if (bits == BCW'(1)) begin
                        st <= F_TAIL;
                    end else begin
                        bits <= bits - 1'b1;
                        txsh <= {txsh[FRAME_W-2:0], 1'b0};
                        st   <= F_LOW;
                    end
                end
                F_TAIL: if (tick) begin
                    cs_n <= 1'b1;
                    st   <= F_GAP;
                end
                F_GAP: if (tick) begin
                    if (gapc)
                        st <= F_IDLE;
                    else
                        gapc <= 1'b1;
                end
                default: st <= F_IDLE;
            endcase
        end
    end

    assign mosi = cs_n ? 1'b0 : txsh[FRAME_W-1];
    assign rx   = rxsh;
endmodule

// File: rtl/pgspi_master.sv
module pgspi_master
    import pgspi_pkg::*;
#(
    parameter int HALF = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [DESC_W-1:0]   req_desc,
    input  logic                req_write,
    input  logic                req_rmw,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [DATA_W-1:0]   req_mask,
    output logic                busy,
    output logic                done,
    output logic [DATA_W-1:0]   rdata,
    output logic                sclk,
    output logic                cs_n,
    output logic                mosi,
    input  logic                miso
);
    mst_state_e st, st_nx;

    // descriptor fields of the incoming request
    logic [BYTE_W-2:0] in_addr;
    logic [BYTE_W-1:0] in_page;
    logic              in_two;
    logic              in_rd;
    logic              unused_desc_b7;

    assign in_addr        = req_desc[BYTE_W-2:0];
    assign unused_desc_b7 = req_desc[BYTE_W-1];
    assign in_page        = req_desc[2*BYTE_W-1:BYTE_W];
    assign in_two         = (req_desc[DESC_W-1:2*BYTE_W] == LEN_TWO);
    assign in_rd          = req_rmw || !req_write;

    // latched request
    logic [BYTE_W-2:0] addr_q;
    logic [BYTE_W-1:0] page_q;
    logic              two_q;
    logic              rd_q;
    logic              rmw_q;
    logic [DATA_W-1:0] wd_q;
    logic [DATA_W-1:0] mk_q;
    logic [BYTE_W-1:0] cur_page;

    // frame engine interface
    logic               f_start;
    logic [FRAME_W-1:0] f_tx;
    logic               f_three;
    logic               f_fin;
    logic [DATA_W-1:0]  f_rx;

    logic [DATA_W-1:0]  rx_val;
    logic [DATA_W-1:0]  merged;
    logic               page_miss;

    assign rx_val    = two_q ? f_rx : {{BYTE_W{1'b0}}, f_rx[BYTE_W-1:0]};
    assign merged    = (rx_val & ~mk_q) | (wd_q & mk_q);
    assign page_miss = (in_page != cur_page);

    function automatic logic [FRAME_W-1:0] acc_frame(
        input logic [BYTE_W-2:0] a,
        input logic              rd,
        input logic              two,
        input logic [DATA_W-1:0] wd
    );
        logic [BYTE_W-1:0] hdr;
        hdr = {rd, a};
        if (rd)
            return {hdr, {DATA_W{1'b0}}};
        else if (two)
            return {hdr, wd};
        else
            return {hdr, wd[BYTE_W-1:0], {BYTE_W{1'b0}}};
    endfunction

    pgspi_frame #(.HALF(HALF)) u_frame (
        .clk  (clk),
        .rst_n(rst_n),
        .start(f_start),
        .tx   (f_tx),
        .three(f_three),
        .fin  (f_fin),
        .rx   (f_rx),
        .sclk (sclk),
        .cs_n (cs_n),
        .mosi (mosi),
        .miso (miso)
    );

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:  if (req_valid) st_nx = page_miss ? S_PAGE : S_XFER;
            S_PAGE:  if (f_fin) st_nx = S_XFER;
            S_XFER:  if (f_fin) st_nx = rmw_q ? S_WBACK : S_IDLE;
            S_WBACK: if (f_fin) st_nx = S_IDLE;
            default: st_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st <= S_IDLE;
        else
            st <= st_nx;
    end

    // frame launch outputs
    always_comb begin
        f_start = 1'b0;
        f_tx    = '0;
        f_three = 1'b0;
        unique case (st)
            S_IDLE: if (req_valid) begin
                f_start = 1'b1;
                if (page_miss) begin
                    f_tx    = {PAGE_SEL_ADDR, in_page, {BYTE_W{1'b0}}};
                    f_three = 1'b0;
                end else begin
                    f_tx    = acc_frame(in_addr, in_rd, in_two, req_wdata);
                    f_three = in_two;
                end
            end
            S_PAGE: if (f_fin) begin
                f_start = 1'b1;
                f_tx    = acc_frame(addr_q, rd_q, two_q, wd_q);
                f_three = two_q;
            end
            S_XFER: if (f_fin && rmw_q) begin
                f_start = 1'b1;
                f_tx    = acc_frame(addr_q, 1'b0, two_q, merged);
                f_three = two_q;
            end
            S_WBACK: ;
            default: ;
        endcase
    end

    // request latch, page cache and result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            page_q   <= '0;
            two_q    <= 1'b0;
            rd_q     <= 1'b0;
            rmw_q    <= 1'b0;
            wd_q     <= '0;
            mk_q     <= '0;
            cur_page <= '0;
            done     <= 1'b0;
            rdata    <= '0;
        end else begin
            done <= 1'b0;
            if (st == S_IDLE && req_valid) begin
                addr_q <= in_addr;
                page_q <= in_page;
                two_q  <= in_two;
                rd_q   <= in_rd;
                rmw_q  <= req_rmw;
                wd_q   <= req_wdata;
                mk_q   <= req_mask;
            end
            if (st == S_PAGE && f_fin)
                cur_page <= page_q;
            if (st == S_XFER && f_fin) begin
                rdata <= rd_q ? rx_val : '0;
                if (!rmw_q)
                    done <= 1'b1;
            end
            if (st == S_WBACK && f_fin)
                done <= 1'b1;
        end
    end

    assign busy = (st != S_IDLE);
endmodule

// File: rtl/pgspi_checker.sv
module pgspi_checker #(
    parameter int HALF = 2
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sclk,
    input logic mosi,
    input logic busy,
    input logic done
);
    localparam int GAP_MIN = 2 * HALF;
    localparam int GW = $clog2(GAP_MIN + 2);

    logic [GW-1:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hi_cnt <= GW'(GAP_MIN);
        else if (cs_n) begin
            if (hi_cnt != {GW{1'b1}})
                hi_cnt <= hi_cnt + 1'b1;
        end else
            hi_cnt <= '0;
    end

    a_r8_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    a_r8_mosi_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    a_r9_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (hi_cnt >= GW'(GAP_MIN)));

    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r11_busy_ends_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
endmodule

bind pgspi_master pgspi_checker #(.HALF(HALF)) u_pgspi_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .cs_n (cs_n),
    .sclk (sclk),
    .mosi (mosi),
    .busy (busy),
    .done (done)
);

// File: tb/pgspi_master_bench.sv
`timescale 1ns/1ps
module pgspi_master_bench;
    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [17:0] req_desc = '0;
    logic        req_write = 1'b0;
    logic        req_rmw = 1'b0;
    logic [15:0] req_wdata = '0;
    logic [15:0] req_mask = '0;
    logic        busy, done, sclk, cs_n, mosi;
    logic [15:0] rdata;
    logic        miso = 1'b0;

    int nchk = 0;
    int nfail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    pgspi_master #(.HALF(HALF)) u_pgspi_master (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_desc(req_desc),
        .req_write(req_write), .req_rmw(req_rmw), .req_wdata(req_wdata),
        .req_mask(req_mask), .busy(busy), .done(done), .rdata(rdata),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    // ---------------- peripheral model ----------------
    logic [15:0] mem [0:2047];
    logic [7:0]  spage = 8'h00;
    bit          slave_len1 = 0;
    logic [7:0]  lg_b [0:7][0:2];
    int          lg_n [0:7];
    int          nfr = 0;

    logic        s_cs_q = 1'b1;
    logic        s_ck_q = 1'b0;
    bit          s_act = 0;
    bit          s_rd = 0;
    int          s_bit = 0;
    int          s_nby = 0;
    logic [7:0]  s_shin = '0;
    logic [15:0] s_out = '0;
    logic [7:0]  s_b [0:2];

    function automatic int idx(input logic [7:0] pg, input logic [7:0] a);
        return int'({pg[3:0], a[6:0]});
    endfunction

    initial begin
        for (int i = 0; i < 2048; i++) mem[i] = 16'(i * 40503) ^ 16'h5A5A;
    end

    always @(cs_n or sclk) begin
        if (cs_n !== s_cs_q) begin
            if (cs_n === 1'b0) begin
                s_act = 1; s_rd = 0; s_bit = 0; s_nby = 0; s_shin = '0; miso = 1'b0;
            end else if (cs_n === 1'b1 && s_act) begin
                s_act = 0;
                if (nfr < 8) begin
                    lg_n[nfr] = s_nby;
                    for (int k = 0; k < 3; k++) lg_b[nfr][k] = (k < s_nby) ? s_b[k] : 8'h00;
                end
                nfr++;
                if (s_nby >= 2 && !s_b[0][7]) begin
                    if (s_nby == 2 && s_b[0] == 8'h01) spage = s_b[1];
                    else if (s_nby == 3) mem[idx(spage, s_b[0])] = {s_b[1], s_b[2]};
                    else mem[idx(spage, s_b[0])] = {8'h00, s_b[1]};
                end
            end
        end else if (sclk !== s_ck_q && cs_n === 1'b0) begin
            if (sclk === 1'b1) begin
                s_shin = {s_shin[6:0], mosi};
                s_bit++;
                if (s_bit == 8) begin
                    if (s_nby < 3) s_b[s_nby] = s_shin;
                    s_nby++;
                    s_bit = 0;
                    if (s_nby == 1 && s_shin[7]) begin
                        s_rd = 1;
                        s_out = slave_len1 ? {mem[idx(spage, s_shin)][7:0], 8'h00}
                                           : mem[idx(spage, s_shin)];
                    end
                end
            end else if (s_rd) begin
                miso = s_out[15];
                s_out = {s_out[14:0], 1'b0};
            end
        end
        s_cs_q = cs_n;
        s_ck_q = sclk;
    end

    // timing monitors
    int hcnt = 0, mingap = 1000, hw = 0, last_hw = 0;
    always @(posedge clk) begin
        if (cs_n === 1'b1) hcnt++;
        else begin
            if (hcnt > 0 && hcnt < mingap) mingap = hcnt;
            hcnt = 0;
        end
        if (sclk === 1'b1) hw++;
        else if (hw > 0) begin last_hw = hw; hw = 0; end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic chk_frame(input string rq, input int i, input int n,
                             input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
        chk(rq, $sformatf("frame%0d length", i), lg_n[i], n);
        chk(rq, $sformatf("frame%0d bytes", i), {8'h00, lg_b[i][0], lg_b[i][1], lg_b[i][2]},
            {8'h00, b0, b1, b2});
    endtask

    task automatic wait_done(output logic [15:0] rd);
        rd = 'x;
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            if (done) begin rd = rdata; break; end
        end
    endtask

    task automatic issue(input logic [17:0] d, input logic w, input logic rmw,
                         input logic [15:0] wd, input logic [15:0] mk, output logic [15:0] rd);
        @(negedge clk);
        req_desc = d; req_write = w; req_rmw = rmw; req_wdata = wd; req_mask = mk;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done(rd);
        @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk("R1", "cs_n idle", cs_n, 1'b1);
        chk("R1", "sclk idle", sclk, 1'b0);
        chk("R1", "busy idle", busy, 1'b0);
        chk("R1", "done idle", done, 1'b0);
    endtask

    task automatic t_first_read();
        logic [15:0] rd, exp;
        nfr = 0; slave_len1 = 0;
        exp = mem[idx(8'h00, 8'h10)];
        issue({2'd2, 8'h00, 8'h10}, 1'b0, 1'b0, 16'h0, 16'h0, rd);
        chk("R1", "no page frame from reset cache", nfr, 1);
        chk_frame("R5", 0, 3, 8'h90, 8'h00, 8'h00);
        chk("R5", "two-byte read data", rd, exp);
    endtask

    task automatic t_page_write();
        logic [15:0] rd;
        nfr = 0; mingap = 1000;
        issue({2'd2, 8'h03, 8'h22}, 1'b1, 1'b0, 16'hBEEF, 16'h0, rd);
        chk("R3", "frame count", nfr, 2);
        chk_frame("R3", 0, 2, 8'h01, 8'h03, 8'h00);
        chk_frame("R6", 1, 3, 8'h22, 8'hBE, 8'hEF);
        chk("R7", "peripheral stored value", mem[idx(8'h03, 8'h22)], 16'hBEEF);
        chk("R3", "peripheral page", spage, 8'h03);
        chk("R9", "cs high gap >= 2*HALF", (mingap >= 2 * HALF), 1'b1);
    endtask

    task automatic t_short_read();
        logic [15:0] rd, exp;
        nfr = 0; slave_len1 = 1;
        exp = {8'h00, mem[idx(8'h03, 8'h05)][7:0]};
        issue({2'd1, 8'h03, 8'h05}, 1'b0, 1'b0, 16'h0, 16'h0, rd);
        slave_len1 = 0;
        chk("R4", "same page: single frame", nfr, 1);
        chk_frame("R7", 0, 2, 8'h85, 8'h00, 8'h00);
        chk("R5", "one-byte read zero-extended", rd, exp);
    endtask

    task automatic t_short_write();
        logic [15:0] rd;
        nfr = 0;
        issue({2'd3, 8'h03, 8'h06}, 1'b1, 1'b0, 16'h12AB, 16'h0, rd);
        chk("R2", "length 3 treated as one byte", nfr, 1);
        chk_frame("R6", 0, 2, 8'h06, 8'hAB, 8'h00);
        chk("R6", "one-byte stored", mem[idx(8'h03, 8'h06)], 16'h00AB);
        chk("R6", "write returns zero rdata", rd, 16'h0000);
    endtask

    task automatic t_rmw();
        logic [15:0] rd, old, nw;
        nfr = 0; mingap = 1000;
        old = mem[idx(8'h05, 8'h30)];
        nw  = (old & ~16'h0FF0) | (16'hABCD & 16'h0FF0);
        issue({2'd2, 8'h05, 8'h30}, 1'b0, 1'b1, 16'hABCD, 16'h0FF0, rd);
        chk("R10", "frame count", nfr, 3);
        chk_frame("R3", 0, 2, 8'h01, 8'h05, 8'h00);
        chk_frame("R10", 1, 3, 8'hB0, 8'h00, 8'h00);
        chk_frame("R10", 2, 3, 8'h30, nw[15:8], nw[7:0]);
        chk("R10", "old value returned", rd, old);
        chk("R10", "merged value stored", mem[idx(8'h05, 8'h30)], nw);
        chk("R9", "gap between chained frames", (mingap >= 2 * HALF), 1'b1);
    endtask

    task automatic t_busy();
        logic [15:0] rd, exp;
        nfr = 0;
        exp = mem[idx(8'h05, 8'h31)];
        @(negedge clk);
        req_desc = {2'd2, 8'h05, 8'h31}; req_write = 1'b0; req_rmw = 1'b0;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R11", "busy after acceptance", busy, 1'b1);
        @(negedge clk);
        req_desc = {2'd2, 8'h07, 8'h12}; req_write = 1'b1; req_wdata = 16'h7777;
        req_valid = 1'b1;
        repeat (10) @(negedge clk);
        req_valid = 1'b0;
        wait_done(rd);
        chk("R5", "read during ignored request", rd, exp);
        @(negedge clk);
        chk("R11", "done lasts one cycle", done, 1'b0);
        chk("R11", "busy low after done", busy, 1'b0);
        repeat (300) @(negedge clk);
        chk("R12", "no frame from ignored request", nfr, 1);
        chk("R12", "page unchanged", spage, 8'h05);
    endtask

    task automatic t_timing();
        chk("R8", "sclk high width", last_hw, HALF);
        chk("R8", "sclk low while idle", sclk, 1'b0);
    endtask

    task automatic t_back_page0();
        logic [15:0] rd, exp;
        nfr = 0;
        exp = mem[idx(8'h00, 8'h10)];
        issue({2'd2, 8'h00, 8'h10}, 1'b0, 1'b0, 16'h0, 16'h0, rd);
        chk("R3", "frame count on return to page 0", nfr, 2);
        chk_frame("R3", 0, 2, 8'h01, 8'h00, 8'h00);
        chk_frame("R5", 1, 3, 8'h90, 8'h00, 8'h00);
        chk("R5", "read data page 0", rd, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_first_read();
        t_page_write();
        t_short_read();
        t_short_write();
        t_rmw();
        t_busy();
        t_timing();
        t_back_page0();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
            $finish;
        end
    end
endmodule